// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block sits on a narrow processor bus and offers three byte-wide parallel ports, called A, B and C, which give 24 I/O lines in total. The processor reaches four registers through a 2-bit register select. Select 00 is port A, 01 is port B, 10 is port C and 11 is the control register. Every access is qualified by an active-low chip select and by active-low read and write strobes. Each pad is modelled as three vectors: a pin input, a driven value and a per-bit output enable. Tri-state pads and wait states sit outside the block.

A control word that has bit 7 set is a configuration word. It picks the operating style of each port and the direction of each port and each half of port C. A control word that has bit 7 clear sets or clears a single line of port C. In simple mode a port is either a latched output or a live input. Ports A and B also have a strobed handshake mode, and port A has a bidirectional handshake mode. In both handshake modes certain port C lines are taken over as strobe, acknowledge, buffer-status and interrupt-request lines. Each interrupt request can be masked by an enable flip-flop, which software writes through the single-line command.

All bus writes and pin events are sampled on the rising edge of `clk`. Read data is combinational while a read is in progress.

Top module: `parPortIo`

## Requirements
- R1: After reset every port is an input (`paOe`, `pbOe` and `pcOe` all 0), every output latch is 0, and `dataOut` is 0.
- R2: A write with select 00, 01 or 10 loads the addressed port's output latch. The port's output shows the value from the next clock and keeps it after the bus cycle ends.
- R3: A configuration word (bit 7 = 1) sets the following fields. Bits 6:5 are the port A mode (00 simple, 01 strobed, 1x bidirectional). Bit 4 is the port A direction. Bit 3 is the direction of port C lines 7..4. Bit 2 is the port B mode (0 simple, 1 strobed). Bit 1 is the port B direction. Bit 0 is the direction of port C lines 3..0. For every direction bit, 1 means input. A port or port C half that is a simple output has all of its enables set.
- R4: A configuration word clears all output latches, all buffer flags, all pending interrupts and all interrupt enables.
- R5: A single-line command (bit 7 = 0) writes bit 0 into the port C line chosen by bits 3:1 and leaves the configuration unchanged. When it targets line 4, 6 or 2, it also writes the port A input enable, the port A output enable or the port B enable.
- R6: In simple mode, a read of an input port returns its pins as they are now, and a read of an output port returns its latch.
- R7: In strobed input mode the strobe is active low, on line 4 for port A and line 2 for port B. Its falling edge latches the port pins and sets the input-full flag, which is line 5 for port A and line 1 for port B. A read returns the latched byte even if the pins have changed since, and the read clears the flag.
- R8: In strobed output mode a data write drives the active-low output-full line low. This is line 7 for port A and line 1 for port B. The falling edge of the acknowledge input drives that line high again. The acknowledge input is line 6 for port A and line 2 for port B.
- R9: The interrupt line (line 3 for port A, line 0 for port B) goes high after a strobe rises while the input-full flag is set, or after an acknowledge rises once the output-full flag has been cleared, and only while the matching enable is 1. A read of the port clears the input interrupt and a write to the port clears the output interrupt.
- R10: In bidirectional mode, port A drives its pins only while line 6 is low, and both the input and the output handshakes on lines 3 to 7 work as described above.
- R11: While chip select is high, writes change no latch, and `dataOut` is 0 whenever no read is in progress.
- R12: In a handshake mode, a read of port C returns the level of each handshake output line. For each strobe or acknowledge line it returns the matching enable flip-flop in that line's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Write data from the processor |
| dataOut | output | 8 | Read data to the processor |
| paIn | input | 8 | Port A pin levels |
| paOut | output | 8 | Port A driven value |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin levels |
| pbOut | output | 8 | Port B driven value |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin levels |
| pcOut | output | 8 | Port C driven value |
| pcOe | output | 8 | Port C output enables |

## Verification
A write sampled on one rising edge shows on the port outputs and on the port C flag lines from that edge onward. The bench therefore checks at the falling edge that follows. Read data is combinational, so the bench samples it in the middle of the read cycle, before the edge at which any read-clear takes effect. Strobe and acknowledge pins are registered once for edge detection, so the flags and interrupt lines they drive change one clock after the pin moves. Each pin step is checked one full cycle after it is applied. The one exception is the bidirectional drive enable, which follows the acknowledge pin combinationally and is checked in the same cycle.

// File: rtl/parPortPkg.sv
package parPortPkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = $clog2(PORT_W);

  // port C line roles used by the handshake modes
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;
  localparam int PC_INTR_B = 0;
  localparam int PC_FLAG_B = 1;
  localparam int PC_HS_B   = 2;

  localparam logic [PORT_W-1:0] RESET_WORD = 8'h9B;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [1:0] aMode;
    logic       aIn;
    logic       cUpIn;
    logic       bMode;
    logic       bIn;
    logic       cLoIn;
  } modeCfg_t;

  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             wrC;
    logic             modeWr;
    logic             bsrWr;
    logic [SEL_W-1:0] bsrBit;
    logic             bsrVal;
    logic             capA;
    logic             capB;
    logic             rdEn;
  } dpStrobe_t;

  typedef struct packed {
    logic ibfA;
    logic obfA;
    logic intrA;
    logic inteAin;
    logic inteAout;
    logic ibfB;
    logic obfB;
    logic intrB;
    logic inteB;
  } hsFlags_t;

  function automatic modeCfg_t decodeMode(input logic [PORT_W-1:0] w);
    modeCfg_t c;
    c.aMode = w[6:5];
    c.aIn   = w[4];
    c.cUpIn = w[3];
    c.bMode = w[2];
    c.bIn   = w[1];
    c.cLoIn = w[0];
    return c;
  endfunction

  function automatic logic aHandIn(input modeCfg_t c);
    return c.aMode[1] | (c.aMode[0] & c.aIn);
  endfunction

  function automatic logic aHandOut(input modeCfg_t c);
    return c.aMode[1] | (c.aMode[0] & ~c.aIn);
  endfunction
endpackage

// File: rtl/parPortCtrl.sv
module parPortCtrl
  import parPortPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PORT_W-1:0]   dataIn,
  input  logic                stbAPin,
  input  logic                ackAPin,
  input  logic                hsBPin,
  output modeCfg_t            cfg,
  output dpStrobe_t           strb,
  output hsFlags_t            flags
);
  modeCfg_t cfgQ;
  regSel_e  sel;
  logic wrCyc, rdCyc;
  logic wrA, wrB, rdA, rdB;
  logic aHsIn, aHsOut, bHsIn, bHsOut;
  logic stbAQ, ackAQ, hsBQ;
  logic stbAFall, stbARise, ackAFall, ackARise, hsBFall, hsBRise;
  logic ibfA, obfA, pendInA, pendOutA, inteAin, inteAout;
  logic ibfB, obfB, pendB, inteB;

  assign sel   = regSel_e'(addr);
  assign wrCyc = ~csN & ~wrN & rdN;
  assign rdCyc = ~csN & ~rdN & wrN;
  assign wrA   = wrCyc && sel == SEL_A;
  assign wrB   = wrCyc && sel == SEL_B;
  assign rdA   = rdCyc && sel == SEL_A;
  assign rdB   = rdCyc && sel == SEL_B;

  assign aHsIn  = aHandIn(cfgQ);
  assign aHsOut = aHandOut(cfgQ);
  assign bHsIn  = cfgQ.bMode & cfgQ.bIn;
  assign bHsOut = cfgQ.bMode & ~cfgQ.bIn;

  assign stbAFall = aHsIn  &  stbAQ & ~stbAPin;
  assign stbARise = aHsIn  & ~stbAQ &  stbAPin;
  assign ackAFall = aHsOut &  ackAQ & ~ackAPin;
  assign ackARise = aHsOut & ~ackAQ &  ackAPin;
  assign hsBFall  = cfgQ.bMode &  hsBQ & ~hsBPin;
  assign hsBRise  = cfgQ.bMode & ~hsBQ &  hsBPin;

  always_comb begin
    strb        = '0;
    strb.wrA    = wrA;
    strb.wrB    = wrB;
    strb.wrC    = wrCyc && sel == SEL_C;
    strb.modeWr = wrCyc && sel == SEL_CTL && dataIn[PORT_W-1];
    strb.bsrWr  = wrCyc && sel == SEL_CTL && !dataIn[PORT_W-1];
    strb.bsrBit = dataIn[SEL_W:1];
    strb.bsrVal = dataIn[0];
    strb.capA   = stbAFall;
    strb.capB   = bHsIn & hsBFall;
    strb.rdEn   = rdCyc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= decodeMode(RESET_WORD);
      stbAQ    <= 1'b1;
      ackAQ    <= 1'b1;
      hsBQ     <= 1'b1;
      ibfA     <= 1'b0;
      obfA     <= 1'b0;
      pendInA  <= 1'b0;
      pendOutA <= 1'b0;
      inteAin  <= 1'b0;
      inteAout <= 1'b0;
      ibfB     <= 1'b0;
      obfB     <= 1'b0;
      pendB    <= 1'b0;
      inteB    <= 1'b0;
    end else begin
      stbAQ <= stbAPin;
      ackAQ <= ackAPin;
      hsBQ  <= hsBPin;
      if (strb.modeWr) begin
        cfgQ     <= decodeMode(dataIn);
        ibfA     <= 1'b0;
        obfA     <= 1'b0;
        pendInA  <= 1'b0;
        pendOutA <= 1'b0;
        inteAin  <= 1'b0;
        inteAout <= 1'b0;
        ibfB     <= 1'b0;
        obfB     <= 1'b0;
        pendB    <= 1'b0;
        inteB    <= 1'b0;
      end else begin
        if (strb.bsrWr) begin
          if (strb.bsrBit == SEL_W'(PC_STB_A)) inteAin  <= strb.bsrVal;
          if (strb.bsrBit == SEL_W'(PC_ACK_A)) inteAout <= strb.bsrVal;
          if (strb.bsrBit == SEL_W'(PC_HS_B))  inteB    <= strb.bsrVal;
        end
        // port A input side
        if (stbAFall)              ibfA <= 1'b1;
        else if (rdA && aHsIn)     ibfA <= 1'b0;
        if (stbARise && ibfA)      pendInA <= 1'b1;
        else if (rdA && aHsIn)     pendInA <= 1'b0;
        // port A output side
        if (wrA && aHsOut)         obfA <= 1'b1;
        else if (ackAFall)         obfA <= 1'b0;
        if (ackARise && !obfA)     pendOutA <= 1'b1;
        else if (wrA && aHsOut)    pendOutA <= 1'b0;
        // port B, one direction at a time
        if (bHsIn && hsBFall)      ibfB <= 1'b1;
        else if (rdB && bHsIn)     ibfB <= 1'b0;
        if (bHsOut && wrB)         obfB <= 1'b1;
        else if (bHsOut && hsBFall) obfB <= 1'b0;
        if (bHsIn && hsBRise && ibfB)       pendB <= 1'b1;
        else if (bHsOut && hsBRise && !obfB) pendB <= 1'b1;
        else if ((rdB && bHsIn) || (wrB && bHsOut)) pendB <= 1'b0;
      end
    end
  end

  assign cfg            = cfgQ;
  assign flags.ibfA     = ibfA;
  assign flags.obfA     = obfA;
  assign flags.intrA    = (pendInA & inteAin) | (pendOutA & inteAout);
  assign flags.inteAin  = inteAin;
  assign flags.inteAout = inteAout;
  assign flags.ibfB     = ibfB;
  assign flags.obfB     = obfB;
  assign flags.intrB    = pendB & inteB;
  assign flags.inteB    = inteB;
endmodule

// File: rtl/parPortData.sv
module parPortData
  import parPortPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PORT_W-1:0]   dataIn,
  input  modeCfg_t            cfg,
  input  dpStrobe_t           strb,
  input  hsFlags_t            flags,
  output logic [PORT_W-1:0]   dataOut,
  input  logic [PORT_W-1:0]   paIn,
  output logic [PORT_W-1:0]   paOut,
  output logic [PORT_W-1:0]   paOe,
  input  logic [PORT_W-1:0]   pbIn,
  output logic [PORT_W-1:0]   pbOut,
  output logic [PORT_W-1:0]   pbOe,
  input  logic [PORT_W-1:0]   pcIn,
  output logic [PORT_W-1:0]   pcOut,
  output logic [PORT_W-1:0]   pcOe
);
  localparam int HALF = PORT_W / 2;

  logic [PORT_W-1:0] aLatch, bLatch, cLatch, aCap, bCap;
  logic [PORT_W-1:0] drvMask, drvVal, inMask, inVal, cRead;
  logic [PORT_W-1:0] aRead, bRead, rdVal;
  logic aHsIn, aHsOut;

  assign aHsIn  = aHandIn(cfg);
  assign aHsOut = aHandOut(cfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLatch <= '0;
      bLatch <= '0;
      cLatch <= '0;
      aCap   <= '0;
      bCap   <= '0;
    end else if (strb.modeWr) begin
      aLatch <= '0;
      bLatch <= '0;
      cLatch <= '0;
      aCap   <= '0;
      bCap   <= '0;
    end else begin
      if (strb.wrA)   aLatch <= dataIn;
      if (strb.wrB)   bLatch <= dataIn;
      if (strb.wrC)   cLatch <= dataIn;
      if (strb.bsrWr) cLatch[strb.bsrBit] <= strb.bsrVal;
      if (strb.capA)  aCap <= paIn;
      if (strb.capB)  bCap <= pbIn;
    end
  end

  // port C lines claimed by the handshake modes
  always_comb begin
    drvMask = '0;
    drvVal  = '0;
    inMask  = '0;
    inVal   = '0;
    if (aHsIn || aHsOut) begin
      drvMask[PC_INTR_A] = 1'b1;
      drvVal[PC_INTR_A]  = flags.intrA;
    end
    if (aHsIn) begin
      drvMask[PC_IBF_A] = 1'b1;
      drvVal[PC_IBF_A]  = flags.ibfA;
      inMask[PC_STB_A]  = 1'b1;
      inVal[PC_STB_A]   = flags.inteAin;
    end
    if (aHsOut) begin
      drvMask[PC_OBF_A] = 1'b1;
      drvVal[PC_OBF_A]  = ~flags.obfA;
      inMask[PC_ACK_A]  = 1'b1;
      inVal[PC_ACK_A]   = flags.inteAout;
    end
    if (cfg.bMode) begin
      drvMask[PC_INTR_B] = 1'b1;
      drvVal[PC_INTR_B]  = flags.intrB;
      drvMask[PC_FLAG_B] = 1'b1;
      drvVal[PC_FLAG_B]  = cfg.bIn ? flags.ibfB : ~flags.obfB;
      inMask[PC_HS_B]    = 1'b1;
      inVal[PC_HS_B]     = flags.inteB;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pcLine
    logic gpOe;
    assign gpOe     = (i >= HALF) ? ~cfg.cUpIn : ~cfg.cLoIn;
    assign pcOe[i]  = drvMask[i] | (~inMask[i] & gpOe);
    assign pcOut[i] = drvMask[i] ? drvVal[i] : cLatch[i];
    assign cRead[i] = drvMask[i] ? drvVal[i] :
                      inMask[i]  ? inVal[i]  :
                      gpOe       ? cLatch[i] : pcIn[i];
  end

  assign paOut = aLatch;
  assign pbOut = bLatch;
  assign paOe  = cfg.aMode[1] ? {PORT_W{~pcIn[PC_ACK_A]}} : {PORT_W{~cfg.aIn}};
  assign pbOe  = {PORT_W{~cfg.bIn}};

  always_comb begin
    if (aHsIn)        aRead = aCap;
    else if (cfg.aIn) aRead = paIn;
    else              aRead = aLatch;
    if (cfg.bMode && cfg.bIn) bRead = bCap;
    else if (cfg.bIn)         bRead = pbIn;
    else                      bRead = bLatch;
    case (regSel_e'(addr))
      SEL_A:   rdVal = aRead;
      SEL_B:   rdVal = bRead;
      SEL_C:   rdVal = cRead;
      default: rdVal = '0;
    endcase
    dataOut = strb.rdEn ? rdVal : '0;
  end
endmodule

// File: rtl/parPortIo.sv
module parPortIo
  import parPortPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                rdN,
  input  logic                wrN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PORT_W-1:0]   dataIn,
  output logic [PORT_W-1:0]   dataOut,
  input  logic [PORT_W-1:0]   paIn,
  output logic [PORT_W-1:0]   paOut,
  output logic [PORT_W-1:0]   paOe,
  input  logic [PORT_W-1:0]   pbIn,
  output logic [PORT_W-1:0]   pbOut,
  output logic [PORT_W-1:0]   pbOe,
  input  logic [PORT_W-1:0]   pcIn,
  output logic [PORT_W-1:0]   pcOut,
  output logic [PORT_W-1:0]   pcOe
);
  modeCfg_t  cfg;
  dpStrobe_t strb;
  hsFlags_t  flags;

  parPortCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .addr    (addr),
    .dataIn  (dataIn),
    .stbAPin (pcIn[PC_STB_A]),
    .ackAPin (pcIn[PC_ACK_A]),
    .hsBPin  (pcIn[PC_HS_B]),
    .cfg     (cfg),
    .strb    (strb),
    .flags   (flags)
  );

  parPortData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .dataIn  (dataIn),
    .cfg     (cfg),
    .strb    (strb),
    .flags   (flags),
    .dataOut (dataOut),
    .paIn    (paIn),
    .paOut   (paOut),
    .paOe    (paOe),
    .pbIn    (pbIn),
    .pbOut   (pbOut),
    .pbOe    (pbOe),
    .pcIn    (pcIn),
    .pcOut   (pcOut),
    .pcOe    (pcOe)
  );
endmodule

// File: rtl/parPortChecker.sv
module parPortChecker
  import parPortPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                rdN,
  input logic                wrN,
  input logic [ADDR_W-1:0]   addr,
  input logic [PORT_W-1:0]   dataIn,
  input logic [PORT_W-1:0]   paOut,
  input logic [PORT_W-1:0]   pbOut,
  input logic [PORT_W-1:0]   pbOe,
  input logic [PORT_W-1:0]   pcOe
);
  logic busWr;
  assign busWr = ~csN & ~wrN & rdN;

  p_latch_a_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && addr == 2'd0) |=> paOut == $past(dataIn));

  p_oe_whole_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pbOe == '0) || (pbOe == '1));

  p_mode_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && addr == 2'd3 && dataIn[7]) |=> (paOut == '0 && pbOut == '0));

  p_bsr_keeps_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && addr == 2'd3 && !dataIn[7]) |=> ($stable(pbOe) && $stable(pcOe)));

  p_no_write_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> ($stable(paOut) && $stable(pbOut)));
endmodule

bind parPortIo parPortChecker u_chk (.*);

// File: tb/tb_parPortIo.sv
module tb_parPortIo;
  logic clk = 1'b0;
  logic rstN, csN, rdN, wrN;
  logic [1:0] addr;
  logic [7:0] dataIn, dataOut, paIn, paOut, paOe, pbIn, pbOut, pbOe, pcIn, pcOut, pcOe;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  parPortIo dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut),
    .paIn(paIn), .paOut(paOut), .paOe(paOe),
    .pbIn(pbIn), .pbOut(pbOut), .pbOe(pbOe),
    .pcIn(pcIn), .pcOut(pcOut), .pcOe(pcOe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addr = a;
    #2 d = dataOut;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; rdN = 1'b1; wrN = 1'b1; addr = '0; dataIn = '0;
    paIn = '0; pbIn = '0; pcIn = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 paOe", paOe, 8'h00);
    chk("R1 pbOe", pbOe, 8'h00);
    chk("R1 pcOe", pcOe, 8'h00);
    chk("R1 paOut", paOut, 8'h00);
    chk("R1 dataOut", dataOut, 8'h00);

    // R3 sweep of all simple-mode direction combinations
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mb;
      mb = 4'(m);
      busWrite(2'd3, {3'b100, mb[3], mb[2], 1'b0, mb[1], mb[0]});
      chk("R3 paOe", paOe, mb[3] ? 8'h00 : 8'hFF);
      chk("R3 pbOe", pbOe, mb[1] ? 8'h00 : 8'hFF);
      chk("R3 pcOe", pcOe, {mb[2] ? 4'h0 : 4'hF, mb[0] ? 4'h0 : 4'hF});
    end

    // R2 / R6 all outputs, full value sweep on port A
    busWrite(2'd3, 8'h80);
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd0, 8'(v));
      chk("R2 paOut", paOut, 8'(v));
      busRead(2'd0, rd);
      chk("R6 read out latch", rd, 8'(v));
    end
    busWrite(2'd1, 8'h5A);
    chk("R2 pbOut", pbOut, 8'h5A);
    busWrite(2'd2, 8'hC3);
    chk("R2 pcOut", pcOut, 8'hC3);
    tick();
    chk("R2 hold", pbOut, 8'h5A);

    // R11 chip select high blocks writes and reads
    @(negedge clk);
    csN = 1'b1; wrN = 1'b0; addr = 2'd0; dataIn = 8'h00;
    @(negedge clk);
    wrN = 1'b1;
    chk("R11 write ignored", paOut, 8'hFF);
    rdN = 1'b0; #2;
    chk("R11 read idle", dataOut, 8'h00);
    rdN = 1'b1;

    // R4 configuration word clears latches
    busWrite(2'd3, 8'h80);
    chk("R4 paOut cleared", paOut, 8'h00);
    chk("R4 pbOut cleared", pbOut, 8'h00);
    chk("R4 pcOut cleared", pcOut, 8'h00);

    // R5 single-line command sweep
    for (int b = 0; b < 8; b++) begin
      busWrite(2'd3, {4'b0000, 3'(b), 1'b1});
      chk("R5 set line", pcOut, 8'(1 << b));
      busWrite(2'd3, {4'b0000, 3'(b), 1'b0});
      chk("R5 clear line", pcOut, 8'h00);
    end
    chk("R5 mode kept", pbOe, 8'hFF);

    // R6 simple inputs read live pins
    busWrite(2'd3, 8'h9B);
    paIn = 8'h3C; pbIn = 8'hE1;
    busRead(2'd0, rd);
    chk("R6 live A", rd, 8'h3C);
    paIn = 8'h81;
    busRead(2'd0, rd);
    chk("R6 live A change", rd, 8'h81);
    busRead(2'd1, rd);
    chk("R6 live B", rd, 8'hE1);

    // R7 / R9 / R12 strobed input on A and B
    busWrite(2'd3, 8'hBF);
    chk("R12 pcOe strobed in", pcOe, 8'h2B);
    busWrite(2'd3, 8'h09);   // port A input enable
    busWrite(2'd3, 8'h05);   // port B enable
    paIn = 8'hA7; pcIn[4] = 1'b0;
    tick();
    chk("R7 ibfA set", {7'b0, pcOut[5]}, 8'h01);
    paIn = 8'h11; pcIn[4] = 1'b1;
    tick();
    chk("R9 intrA raised", {7'b0, pcOut[3]}, 8'h01);
    busRead(2'd2, rd);
    chk("R12 status read", rd, 8'hFC);
    busRead(2'd0, rd);
    chk("R7 latched data", rd, 8'hA7);
    chk("R7 ibfA cleared", {7'b0, pcOut[5]}, 8'h00);
    chk("R9 intrA cleared", {7'b0, pcOut[3]}, 8'h00);
    busRead(2'd2, rd);
    chk("R12 status after read", rd, 8'hD4);
    busWrite(2'd3, 8'h04);   // disable port B interrupt
    pbIn = 8'h6E; pcIn[2] = 1'b0;
    tick();
    pbIn = 8'h00; pcIn[2] = 1'b1;
    tick();
    chk("R7 ibfB set", {7'b0, pcOut[1]}, 8'h01);
    chk("R9 intrB masked", {7'b0, pcOut[0]}, 8'h00);
    busRead(2'd1, rd);
    chk("R7 latched B", rd, 8'h6E);
    chk("R7 ibfB cleared", {7'b0, pcOut[1]}, 8'h00);

    // R8 / R9 strobed output on A and B
    busWrite(2'd3, 8'hAD);
    chk("R8 pcOe strobed out", pcOe, 8'h8B);
    chk("R8 obfA idle high", {7'b0, pcOut[7]}, 8'h01);
    busWrite(2'd3, 8'h0D);   // port A output enable
    chk("R5 mode kept out", pcOe, 8'h8B);
    busWrite(2'd0, 8'h99);
    chk("R8 paOut", paOut, 8'h99);
    chk("R8 obfA low", {7'b0, pcOut[7]}, 8'h00);
    pcIn[6] = 1'b0;
    tick();
    chk("R8 obfA released", {7'b0, pcOut[7]}, 8'h01);
    pcIn[6] = 1'b1;
    tick();
    chk("R9 intrA out raised", {7'b0, pcOut[3]}, 8'h01);
    busWrite(2'd0, 8'h42);
    chk("R9 intrA out cleared", {7'b0, pcOut[3]}, 8'h00);
    busWrite(2'd1, 8'h77);
    chk("R8 obfB low", {7'b0, pcOut[1]}, 8'h00);
    pcIn[2] = 1'b0;
    tick();
    chk("R8 obfB released", {7'b0, pcOut[1]}, 8'h01);
    pcIn[2] = 1'b1;
    tick();
    chk("R9 intrB no enable", {7'b0, pcOut[0]}, 8'h00);

    // R10 bidirectional port A
    busWrite(2'd3, 8'hC0);
    chk("R10 pcOe", pcOe, 8'hAF);
    chk("R10 pbOe", pbOe, 8'hFF);
    busWrite(2'd3, 8'h0D);
    busWrite(2'd3, 8'h09);
    busWrite(2'd0, 8'h5E);
    chk("R10 obf low", {7'b0, pcOut[7]}, 8'h00);
    chk("R10 released bus", paOe, 8'h00);
    pcIn[6] = 1'b0; #1;
    chk("R10 drive on ack", paOe, 8'hFF);
    chk("R10 drive value", paOut, 8'h5E);
    tick();
    chk("R10 obf high", {7'b0, pcOut[7]}, 8'h01);
    pcIn[6] = 1'b1;
    tick();
    chk("R10 intr on ack", {7'b0, pcOut[3]}, 8'h01);
    chk("R10 bus released", paOe, 8'h00);
    paIn = 8'hB4; pcIn[4] = 1'b0;
    tick();
    chk("R10 ibf set", {7'b0, pcOut[5]}, 8'h01);
    pcIn[4] = 1'b1; paIn = 8'h00;
    tick();
    busRead(2'd0, rd);
    chk("R10 input byte", rd, 8'hB4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule